// File: doc/BRIEF.md
# Configurable-Timing SPI Word Shifter

This block is the serial engine of an SPI master. It moves a single word of up to `MAX_BITS` bits per transfer, sending on `mosi` and collecting on `miso` at the same time. It also generates the serial clock and the frame-select line.

The serial clock comes from the internal clock through an even ratio. Four independent timing bits shape the clock:
- the idle level of the clock;
- which edge samples the incoming data;
- whether the first clock edge is held back;
- which reference edge the frame is aligned to, which sets how long that hold-back lasts.

The frame-select polarity, the word length and the bit order are also programmable.

A host places the word and the settings on the inputs and pulses `start`. The engine copies every setting on that edge and runs on its own. When the clock has returned to its idle level, the engine reports the received word with a one-cycle `done` pulse. In the same cycle `busy` falls.

Top module: `spi_shift_engine`

## Requirements
- R1: While not busy, `sclk` equals `clk_idle_hi` (1 = high, 0 = low). `fs` sits at the inverse of `fs_act_hi`, `mosi` is 0, and `busy` is 0.
- R2: A `start` seen while idle raises `busy` from the next cycle and copies all configuration and `tx_word`. A `start` or a change on any configuration or data input while busy has no effect on that transfer.
- R3: The half-period H is floor(`ratio`/2) internal cycles, with a minimum of 1. During a transfer `sclk` toggles exactly 2N times, with H cycles between successive toggles.
- R4: The lead-in D, in half-periods, is chosen as follows. D is 0 when `first_delay` is 0. When `first_delay` is 1, D is 2 if `start_fall` is 0 (frame aligned to a rising reference edge) and 1 if `start_fall` is 1. The first toggle comes (D+1)·H cycles after the edge that accepted `start`.
- R5: With `cap_fall` = 0, `miso` is sampled on edges where `sclk` rises. With `cap_fall` = 1, it is sampled where `sclk` falls.
- R6: The first bit appears on `mosi` when the frame starts. `mosi` then changes only on non-sampling edges that follow at least one sampling edge, so each bit is stable at its own sampling edge.
- R7: N equals `word_len` when it lies in 1..`MAX_BITS`. A value of 0, or a value above `MAX_BITS`, gives N = `MAX_BITS`.
- R8: A `bit_order` value of 1 sends and receives bit 0 first. Any other value uses bit N-1 first. The k-th received bit lands in the position its index maps to, and bits above N-1 of `rx_word` are 0.
- R9: While busy, `fs` is held at the level given by the copied `fs_act_hi` (1 = active high).
- R10: The last toggle comes at E = (D+2N)·H cycles after the accepting edge. One cycle later `busy` falls, `done` is high for exactly one cycle, and `rx_word` carries the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a transfer when idle |
| tx_word | input | MAX_BITS | Word to send, right-aligned |
| ratio | input | RATIO_W | Serial clock period in internal cycles (even) |
| cap_fall | input | 1 | Sampling edge: 0 rising, 1 falling |
| clk_idle_hi | input | 1 | Idle level of the serial clock |
| first_delay | input | 1 | Hold back the first clock edge |
| start_fall | input | 1 | Frame reference edge: 0 rising, 1 falling |
| fs_act_hi | input | 1 | Frame-select active level |
| word_len | input | LEN_W | Bits per word |
| bit_order | input | 2 | Bit order code, 1 = LSB first |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| fs | output | 1 | Frame select |
| rx_word | output | MAX_BITS | Last received word, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the engine with `MAX_BITS` = 8, keeping `LEN_W` = 6 and `RATIO_W` = 8. The narrow word makes it affordable to sweep all sixteen combinations of the four timing bits against every `bit_order` code, three lengths and three ratios, including ratio 0 and an odd ratio. The 6-bit length field can express 0 and values above 8, so the clamping of R7 is within reach. Some runs disturb every input mid-transfer, which exercises the copy-on-start behaviour of R2.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xfer_state_e;

  localparam logic [1:0] LSB_FIRST_CODE = 2'd1;

  // Half-period length in internal cycles, never below one.
  function automatic int half_len(input int ratio);
    int h;
    h = ratio / 2;
    return (h < 1) ? 1 : h;
  endfunction

  // Half-periods of lead-in before the first serial clock edge.
  function automatic int lead_halves(input logic dly, input logic sfall);
    if (!dly) return 0;
    return sfall ? 1 : 2;
  endfunction

  // Effective word length after clamping.
  function automatic int eff_len(input int len, input int maxb);
    return (len < 1 || len > maxb) ? maxb : len;
  endfunction

  // Word position of the k-th bit on the wire.
  function automatic int bit_pos(input int idx, input int n, input logic lsb);
    return lsb ? idx : (n - 1 - idx);
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear || !run)  cnt_q <= '0;
    else if (tick)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/spi_edge_seq.sv
module spi_edge_seq #(
  parameter int IDX_W  = 6,
  parameter int EDGE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             idle_lvl,
  input  logic [1:0]       lead,
  input  logic [IDX_W-1:0] nbits,
  input  logic             cap_fall,
  input  logic             tick,
  output logic             sclk_lvl,
  output logic             edge_now,
  output logic             cap_now,
  output logic             launch_now,
  output logic             last_edge
);
  logic              sclk_q;
  logic [1:0]        lead_left_q;
  logic [EDGE_W-1:0] ecnt_q;
  logic [IDX_W-1:0]  nbits_q;
  logic              cap_fall_q;
  logic              next_lvl;

  assign next_lvl   = !sclk_q;
  assign edge_now   = tick && (lead_left_q == 2'd0);
  // rising edge samples when cap_fall is 0, falling edge when 1
  assign cap_now    = edge_now && (next_lvl == !cap_fall_q);
  assign launch_now = edge_now && !cap_now;
  assign last_edge  = edge_now && (ecnt_q == ({nbits_q, 1'b0} - EDGE_W'(1)));
  assign sclk_lvl   = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      lead_left_q <= 2'd0;
      ecnt_q      <= '0;
      nbits_q     <= '0;
      cap_fall_q  <= 1'b0;
    end else if (load) begin
      sclk_q      <= idle_lvl;
      lead_left_q <= lead;
      ecnt_q      <= '0;
      nbits_q     <= nbits;
      cap_fall_q  <= cap_fall;
    end else if (tick) begin
      if (lead_left_q != 2'd0) begin
        lead_left_q <= lead_left_q - 2'd1;
      end else begin
        sclk_q <= next_lvl;
        ecnt_q <= ecnt_q + EDGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_bit_lane.sv
module spi_bit_lane
  import spi_shift_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [IDX_W-1:0]    nbits,
  input  logic                lsb,
  input  logic                cap_now,
  input  logic                launch_now,
  input  logic                miso,
  output logic                mosi_bit,
  output logic [MAX_BITS-1:0] rx_acc
);
  localparam int POS_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [MAX_BITS-1:0] tx_q;
  logic [MAX_BITS-1:0] acc_q;
  logic [IDX_W-1:0]    tidx_q;
  logic [IDX_W-1:0]    cidx_q;
  logic [IDX_W-1:0]    nbits_q;
  logic                lsb_q;
  logic                seen_cap_q;
  logic                mosi_q;
  logic [IDX_W-1:0]    tnext;
  logic [POS_W-1:0]    first_pos;
  logic [POS_W-1:0]    next_pos;
  logic [POS_W-1:0]    cap_pos;

  assign tnext     = tidx_q + IDX_W'(1);
  assign first_pos = POS_W'(bit_pos(0, int'(nbits), lsb));
  assign next_pos  = POS_W'(bit_pos(int'(tnext), int'(nbits_q), lsb_q));
  assign cap_pos   = POS_W'(bit_pos(int'(cidx_q), int'(nbits_q), lsb_q));
  assign mosi_bit  = mosi_q;
  assign rx_acc    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      acc_q      <= '0;
      tidx_q     <= '0;
      cidx_q     <= '0;
      nbits_q    <= '0;
      lsb_q      <= 1'b0;
      seen_cap_q <= 1'b0;
      mosi_q     <= 1'b0;
    end else if (load) begin
      tx_q       <= tx_word;
      acc_q      <= '0;
      tidx_q     <= '0;
      cidx_q     <= '0;
      nbits_q    <= nbits;
      lsb_q      <= lsb;
      seen_cap_q <= 1'b0;
      mosi_q     <= tx_word[first_pos];
    end else begin
      if (cap_now) begin
        acc_q[cap_pos] <= miso;
        cidx_q         <= cidx_q + IDX_W'(1);
        seen_cap_q     <= 1'b1;
      end
      if (launch_now && seen_cap_q && (tnext < nbits_q)) begin
        tidx_q <= tnext;
        mosi_q <= tx_q[next_pos];
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_shift_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6,
  parameter int RATIO_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [RATIO_W-1:0]  ratio,
  input  logic                cap_fall,
  input  logic                clk_idle_hi,
  input  logic                first_delay,
  input  logic                start_fall,
  input  logic                fs_act_hi,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [1:0]          bit_order,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                fs,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                done,
  output logic                busy
);
  localparam int HALF_W = RATIO_W;
  localparam int IDX_W  = $clog2(MAX_BITS + 1);
  localparam int EDGE_W = IDX_W + 1;

  xfer_state_e         state_q;
  logic [HALF_W-1:0]   half_q;
  logic                fspol_q;
  logic                done_q;
  logic [MAX_BITS-1:0] rx_q;

  logic [HALF_W-1:0]   live_half;
  logic [1:0]          live_lead;
  logic [IDX_W-1:0]    live_nbits;
  logic                live_lsb;
  logic                accept;
  logic                in_run;
  logic                tick;
  logic                sclk_lvl;
  logic                edge_now;
  logic                cap_now;
  logic                launch_now;
  logic                last_edge;
  logic                mosi_bit;
  logic [MAX_BITS-1:0] rx_acc;

  assign live_half  = HALF_W'(half_len(int'(ratio)));
  assign live_lead  = 2'(lead_halves(first_delay, start_fall));
  assign live_nbits = IDX_W'(eff_len(int'(word_len), MAX_BITS));
  assign live_lsb   = (bit_order == LSB_FIRST_CODE);
  assign accept     = start && (state_q == ST_IDLE);
  assign in_run     = (state_q == ST_RUN);

  spi_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_run),
    .clear (accept),
    .half  (half_q),
    .tick  (tick)
  );

  spi_edge_seq #(.IDX_W(IDX_W), .EDGE_W(EDGE_W)) u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .idle_lvl   (clk_idle_hi),
    .lead       (live_lead),
    .nbits      (live_nbits),
    .cap_fall   (cap_fall),
    .tick       (tick),
    .sclk_lvl   (sclk_lvl),
    .edge_now   (edge_now),
    .cap_now    (cap_now),
    .launch_now (launch_now),
    .last_edge  (last_edge)
  );

  spi_bit_lane #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .tx_word    (tx_word),
    .nbits      (live_nbits),
    .lsb        (live_lsb),
    .cap_now    (cap_now),
    .launch_now (launch_now),
    .miso       (miso),
    .mosi_bit   (mosi_bit),
    .rx_acc     (rx_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= HALF_W'(1);
      fspol_q <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          half_q  <= live_half;
          fspol_q <= fs_act_hi;
        end
        ST_RUN:  if (last_edge) state_q <= ST_FIN;
        ST_FIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          rx_q    <= rx_acc;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign sclk    = busy ? sclk_lvl : clk_idle_hi;
  assign mosi    = busy ? mosi_bit : 1'b0;
  assign fs      = busy ? fspol_q : !fs_act_hi;
  assign done    = done_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic fs,
  input logic clk_idle_hi,
  input logic fs_act_hi,
  input logic in_run,
  input logic edge_now
);
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == clk_idle_hi && !mosi && fs == !fs_act_hi));

  a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_sclk_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !edge_now) |=> $stable(sclk));

  a_r9_fs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fs));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_busy_drop_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .sclk        (sclk),
  .mosi        (mosi),
  .fs          (fs),
  .clk_idle_hi (clk_idle_hi),
  .fs_act_hi   (fs_act_hi),
  .in_run      (in_run),
  .edge_now    (edge_now)
);

// File: tb/spi_shift_engine_tb_top.sv
module spi_shift_engine_tb_top;
  localparam int MB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MB-1:0] tx_word = '0;
  logic [7:0]    ratio = 8'd2;
  logic          cap_fall = 1'b0, clk_idle_hi = 1'b0, first_delay = 1'b0;
  logic          start_fall = 1'b0, fs_act_hi = 1'b0;
  logic [5:0]    word_len = 6'd8;
  logic [1:0]    bit_order = 2'd0;
  logic          miso = 1'b0;
  logic          sclk, mosi, fs, done, busy;
  logic [MB-1:0] rx_word;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_shift_engine #(.MAX_BITS(MB), .LEN_W(6), .RATIO_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .ratio(ratio),
    .cap_fall(cap_fall), .clk_idle_hi(clk_idle_hi), .first_delay(first_delay),
    .start_fall(start_fall), .fs_act_hi(fs_act_hi), .word_len(word_len),
    .bit_order(bit_order), .miso(miso), .sclk(sclk), .mosi(mosi), .fs(fs),
    .rx_word(rx_word), .done(done), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wpos(int i, int n, bit lsb);
    if (lsb) return i;
    return n - 1 - i;
  endfunction

  task automatic run_xfer(input logic [3:0] tm, input int rat, input int len, input int ord,
                          input bit pol, input logic [MB-1:0] tx, input logic [MB-1:0] srx,
                          input bit disturb);
    int h, d, n, e, k, toggles, first_k, last_k, done_cnt, done_k, ci, sb;
    bit lsb, seen, gap_ok, busy_ok, fs_ok, rx_ok, prev, cf;
    logic [MB-1:0] mask, got;
    cf  = tm[3];
    h   = (rat / 2 < 1) ? 1 : rat / 2;
    d   = tm[1] ? (tm[0] ? 1 : 2) : 0;
    n   = (len < 1 || len > MB) ? MB : len;
    e   = (d + 2 * n) * h;
    lsb = (ord == 1);
    mask = (n == MB) ? '1 : MB'((1 << n) - 1);
    @(negedge clk);
    cap_fall = tm[3]; clk_idle_hi = tm[2]; first_delay = tm[1]; start_fall = tm[0];
    ratio = 8'(rat); word_len = 6'(len); bit_order = 2'(ord); fs_act_hi = pol;
    tx_word = tx; sb = 0; miso = srx[wpos(0, n, lsb)];
    #1;
    // R1: idle outputs follow live settings
    check(sclk == tm[2] && fs == !pol && !mosi && !busy && !done, "R1", {sclk, fs, mosi, busy}, {tm[2], !pol, 2'b00});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    toggles = 0; first_k = -1; last_k = -1; done_cnt = 0; done_k = -1; ci = 0;
    seen = 0; gap_ok = 1; busy_ok = 1; fs_ok = 1; rx_ok = 1; got = '0; prev = tm[2];
    for (k = 0; k <= e + 2; k++) begin
      if (k > 0) @(negedge clk);
      if (disturb && k == 2) begin
        start = 1'b1; tx_word = ~tx; ratio = 8'(rat + 8); word_len = 6'd2;
        bit_order = ~bit_order; cap_fall = ~cap_fall; first_delay = ~first_delay;
        start_fall = ~start_fall;
      end
      if (disturb && k == 3) start = 1'b0;
      if (disturb && k == e) begin
        cap_fall = tm[3]; first_delay = tm[1]; start_fall = tm[0];
        ratio = 8'(rat); word_len = 6'(len); bit_order = 2'(ord); tx_word = tx;
      end
      if (k <= e) begin
        if (!busy) busy_ok = 0;
        if (fs != pol) fs_ok = 0;
      end else if (k == e + 1) begin
        if (busy || fs != !pol) busy_ok = 0;
      end
      if (sclk != prev) begin
        toggles++;
        if (first_k < 0) first_k = k;
        else if (k - last_k != h) gap_ok = 0;
        last_k = k;
        if (sclk == !cf) begin
          if (ci < n) got[wpos(ci, n, lsb)] = mosi;
          ci++; seen = 1;
        end else if (seen && sb + 1 < n) begin
          sb++; miso = srx[wpos(sb, n, lsb)];
        end
        prev = sclk;
      end
      if (done) begin
        done_cnt++; done_k = k;
        if (rx_word != (srx & mask)) rx_ok = 0;
      end
    end
    check(first_k == (d + 1) * h, "R4", first_k, (d + 1) * h);
    check(toggles == 2 * n && gap_ok, "R3", toggles, 2 * n);
    check(done_cnt == 1 && done_k == e + 1, "R10", done_k, e + 1);
    check(busy_ok, disturb ? "R2" : "R10", busy_ok, 1);
    check(fs_ok, "R9", fs_ok, 1);
    check(got == (tx & mask), lsb ? "R6 R8" : "R6", got, tx & mask);
    check(rx_ok && rx_word == (srx & mask), (len < 1 || len > MB) ? "R7" : "R5", rx_word, srx & mask);
  endtask

  initial begin
    logic [MB-1:0] seed;
    int rats[3];
    int lens[3];
    rats = '{0, 2, 5};
    lens = '{1, 5, 8};
    seed = 8'h5b;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && rx_word == '0, "R1", busy, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int o = 0; o < 4; o++) begin
        for (int r = 0; r < 3; r++) begin
          for (int l = 0; l < 3; l++) begin
            seed = seed * 8'd29 + 8'd71;
            run_xfer(4'(m), rats[r], lens[l], o, bit'((m + l) & 1), seed, ~(seed ^ 8'h3c), 1'b0);
          end
        end
      end
    end
    // R7: out-of-range lengths clamp to the full width
    run_xfer(4'b0010, 2, 0, 0, 1'b1, 8'hc5, 8'h3a, 1'b0);
    run_xfer(4'b1101, 4, 13, 1, 1'b0, 8'h96, 8'he1, 1'b0);
    // R2: inputs disturbed mid-transfer
    run_xfer(4'b0010, 2, 6, 0, 1'b1, 8'h2d, 8'h17, 1'b1);
    run_xfer(4'b1101, 6, 8, 1, 1'b0, 8'hb4, 8'h69, 1'b1);
    run_xfer(4'b0111, 0, 3, 3, 1'b1, 8'h05, 8'h06, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule